// File: doc/BRIEF.md
# Full-Bridge Gate Sequencer with Dead-Time

This block drives the four gate-enable lines of an N-channel full bridge: low and high switch of leg A, low and high switch of leg B. It takes a direction bit (the result of comparing the two control inputs), a high-side enable, a disable request and an undervoltage flag. From these it picks a target state for each switch using a fixed priority. Disable and undervoltage win over everything else. Next comes the phase the sequencer is in, then the direction bit and the high-side enable.

Each output switches off on the edge that first sees its target false. Each output switches on only after its own dead-time count of cycles. One count is shared by the two low-side switches and a separate count by the two high-side switches, and both are taken from ports. Pulling the high-side enable low gives a chop mode: both upper switches stay off and current freewheels in the lower pair.

When disable or undervoltage is released, the sequencer first turns both low-side switches on for a refresh window, so the bootstrap capacitors can recharge. The high-side switches may turn on only after a longer upper-enable interval, counted from the same release edge. The direction, high-side enable and disable inputs each pass through a two-flop synchronizer. The undervoltage flag is taken as already synchronous.

Top module: `fbg_bridge_seq`

## Requirements
- R1: While `rst` is high, and on the edges just after it, all four outputs are 0 and the sequencer is in its halted phase.
- R2: Once `dis_in` high has passed its synchronizer, all four outputs are 0 on the third edge after it is first sampled, and they stay 0 whatever `dir_in` and `hen_in` do.
- R3: With `uv_in` high, all four outputs are 0 from the first edge that samples it, regardless of `dir_in` and `hen_in`.
- R4: In the run phase with `hen_in`=1, `dir_in`=1 targets `a_hi` and `b_lo` on with `a_lo` and `b_hi` off, and `dir_in`=0 targets `a_lo` and `b_hi` on with `a_hi` and `b_lo` off.
- R5: With `hen_in`=0, both high-side outputs are 0 on the third edge after sampling. The low-side outputs still follow the direction: `b_lo` for 1, `a_lo` for 0.
- R6: A low-side output goes to 0 on the first edge at which its target is false. It goes to 1 on the edge at which its target has been true for `lo_dead`+1 consecutive edges.
- R7: A high-side output obeys the same rule as R6 using `hi_dead`, which is independent of `lo_dead`.
- R8: When the release edge R leaves the halted phase, both low-side targets are on for `REF_CYC` cycles. `b_lo`/`a_lo` then follow the direction rule from edge R+`REF_CYC`. High-side targets stay off until edge R+`UEN_CYC`, with `UEN_CYC` > `REF_CYC`.
- R9: If a target drops before its turn-on delay has elapsed, the output stays 0 and the delay count restarts from zero when the target returns.
- R10: A dead-time count of 0 turns the output on at the first edge that sees its target true.
- R11: `a_lo` and `a_hi` are never 1 in the same cycle, nor are `b_lo` and `b_hi`.
- R12: `dir_in`, `hen_in` and `dis_in` act through two synchronizer flops. A change in any of them has no effect on the outputs at the second edge after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_in | input | 1 | Direction bit: 1 when the plus input exceeds the minus input |
| hen_in | input | 1 | High-side enable; 0 holds both upper switches off |
| dis_in | input | 1 | Disable request; 1 forces all outputs off |
| uv_in | input | 1 | Undervoltage flag, already synchronous; 1 forces all outputs off |
| lo_dead | input | DW | Low-side turn-on delay in cycles |
| hi_dead | input | DW | High-side turn-on delay in cycles |
| a_lo | output | 1 | Leg A low-side gate enable |
| a_hi | output | 1 | Leg A high-side gate enable |
| b_lo | output | 1 | Leg B low-side gate enable |
| b_hi | output | 1 | Leg B high-side gate enable |

## Verification
The bench flips direction in the run phase. A design that delayed turn-off or shared one dead-time between both sides would show a leg overlap, or a switch-on at the wrong edge. It sends a high-side enable pulse shorter than the high dead-time and then re-enables. A counter that fails to restart would fire the upper switch early, and a cancelled turn-on that leaked would glitch it. Releases from both disable and undervoltage are timed edge by edge against the refresh and upper-enable windows. A zero-delay run checks that off and on swap on one edge without an overlap cycle.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  typedef enum logic [1:0] {
    PH_HALT    = 2'd0,
    PH_REFRESH = 2'd1,
    PH_HOLD    = 2'd2,
    PH_RUN     = 2'd3
  } phase_e;

  localparam int GATE_N = 4;
  localparam int GI_ALO = 0;
  localparam int GI_AHI = 1;
  localparam int GI_BLO = 2;
  localparam int GI_BHI = 3;
endpackage

// File: rtl/fbg_sync.sv
module fbg_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fbg_phase.sv
module fbg_phase
  import fbg_pkg::*;
#(
  parameter int REF_CYC = 380,
  parameter int UEN_CYC = 480
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   blocked,
  output phase_e phase
);
  localparam int TW = $clog2(UEN_CYC + 1);
  localparam logic [TW-1:0] REF_LAST = TW'(REF_CYC - 1);
  localparam logic [TW-1:0] UEN_LAST = TW'(UEN_CYC - 1);

  logic [TW-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst || blocked) begin
      phase <= PH_HALT;
      tmr   <= '0;
    end else begin
      case (phase)
        PH_HALT: begin
          phase <= PH_REFRESH;
          tmr   <= '0;
        end
        PH_REFRESH: begin
          tmr <= tmr + 1'b1;
          if (tmr == REF_LAST) phase <= PH_HOLD;
        end
        PH_HOLD: begin
          tmr <= tmr + 1'b1;
          if (tmr == UEN_LAST) phase <= PH_RUN;
        end
        default: phase <= PH_RUN;
      endcase
    end
  end
endmodule

// File: rtl/fbg_deadtime.sv
module fbg_deadtime #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tgt,
  input  logic [DW-1:0] dly,
  output logic          q
);
  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !tgt) begin
      q   <= 1'b0;
      cnt <= '0;
    end else if (!q) begin
      if (cnt >= dly) q <= 1'b1;
      else            cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fbg_bridge_seq.sv
module fbg_bridge_seq
  import fbg_pkg::*;
#(
  parameter int DW      = 8,
  parameter int REF_CYC = 380,
  parameter int UEN_CYC = 480
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dir_in,
  input  logic          hen_in,
  input  logic          dis_in,
  input  logic          uv_in,
  input  logic [DW-1:0] lo_dead,
  input  logic [DW-1:0] hi_dead,
  output logic          a_lo,
  output logic          a_hi,
  output logic          b_lo,
  output logic          b_hi
);
  logic              dir_s, hen_s, dis_s;
  logic              blocked;
  logic              hen_ok;
  phase_e            phase;
  logic [GATE_N-1:0] tgt;
  logic [GATE_N-1:0] gate;

  fbg_sync #(.W(2), .RST_VAL(2'b00)) u_sync_ctl (
    .clk(clk), .rst(rst), .d({dir_in, hen_in}), .q({dir_s, hen_s})
  );

  fbg_sync #(.W(1), .RST_VAL(1'b1)) u_sync_dis (
    .clk(clk), .rst(rst), .d(dis_in), .q(dis_s)
  );

  assign blocked = dis_s | uv_in;

  fbg_phase #(.REF_CYC(REF_CYC), .UEN_CYC(UEN_CYC)) u_phase (
    .clk(clk), .rst(rst), .blocked(blocked), .phase(phase)
  );

  assign hen_ok = hen_s && (phase == PH_RUN);

  always_comb begin
    tgt = '0;
    if (!blocked) begin
      case (phase)
        PH_REFRESH: begin
          tgt[GI_ALO] = 1'b1;
          tgt[GI_BLO] = 1'b1;
        end
        PH_HOLD, PH_RUN: begin
          if (dir_s) begin
            tgt[GI_BLO] = 1'b1;
            tgt[GI_AHI] = hen_ok;
          end else begin
            tgt[GI_ALO] = 1'b1;
            tgt[GI_BHI] = hen_ok;
          end
        end
        default: tgt = '0;
      endcase
    end
  end

  for (genvar gi = 0; gi < GATE_N; gi++) begin : g_gate
    fbg_deadtime #(.DW(DW)) u_dt (
      .clk(clk),
      .rst(rst),
      .tgt(tgt[gi]),
      .dly((gi % 2 == 1) ? hi_dead : lo_dead),
      .q(gate[gi])
    );
  end

  assign a_lo = gate[GI_ALO];
  assign a_hi = gate[GI_AHI];
  assign b_lo = gate[GI_BLO];
  assign b_hi = gate[GI_BHI];
endmodule

// File: rtl/fbg_bridge_seq_chk.sv
module fbg_bridge_seq_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          dir_in,
  input logic          hen_in,
  input logic          dis_in,
  input logic          uv_in,
  input logic [DW-1:0] lo_dead,
  input logic [DW-1:0] hi_dead,
  input logic          a_lo,
  input logic          a_hi,
  input logic          b_lo,
  input logic          b_hi
);
  AST_LEG_A_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(a_lo && a_hi)); // R11
  AST_LEG_B_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(b_lo && b_hi)); // R11
  AST_UV_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    uv_in |=> !(a_lo || a_hi || b_lo || b_hi)); // R3
  AST_DIS_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
    $past(dis_in, 3) |-> !(a_lo || a_hi || b_lo || b_hi)); // R2
  AST_CHOP_HI_OFF: assert property (@(posedge clk) disable iff (rst)
    !$past(hen_in, 3) |-> !(a_hi || b_hi)); // R5
endmodule

bind fbg_bridge_seq fbg_bridge_seq_chk #(.DW(DW)) u_chk (.*);

// File: tb/fbg_bridge_seq_bench.sv
`timescale 1ns/1ps
module fbg_bridge_seq_bench;
  localparam int DW = 6;

  typedef struct {
    logic [3:0] exp;
    string      req;
  } item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dir_in = 1'b0, hen_in = 1'b0, dis_in = 1'b1, uv_in = 1'b0;
  logic [DW-1:0] lo_dead = 6'd3, hi_dead = 6'd5;
  logic          a_lo, a_hi, b_lo, b_hi;

  item_t sbq[$];
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  always #4 clk = ~clk;

  fbg_bridge_seq #(.DW(DW), .REF_CYC(12), .UEN_CYC(20)) u_fbg_bridge_seq (
    .clk(clk), .rst(rst), .dir_in(dir_in), .hen_in(hen_in), .dis_in(dis_in),
    .uv_in(uv_in), .lo_dead(lo_dead), .hi_dead(hi_dead),
    .a_lo(a_lo), .a_hi(a_hi), .b_lo(b_lo), .b_hi(b_hi)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // expected order {a_lo, a_hi, b_lo, b_hi}
  task automatic expect_out(input logic [3:0] e, input string r);
    item_t it;
    it.exp = e;
    it.req = r;
    sbq.push_back(it);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      n_vec++;
      if ({a_lo, a_hi, b_lo, b_hi} !== it.exp) begin
        n_bad++;
        $display("FAIL %s: got %b expected %b at %0t", it.req,
                 {a_lo, a_hi, b_lo, b_hi}, it.exp, $time);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    tick(3);
    expect_out(4'b0000, "R1 in reset");
    rst = 1'b0;
    tick(4);
    expect_out(4'b0000, "R2 disable held after reset");

    // release from disable, dir 0, hen 1
    dis_in = 1'b0; hen_in = 1'b1; dir_in = 1'b0;
    tick(6);  expect_out(4'b0000, "R8 low refresh waits lo_dead");
    tick(1);  expect_out(4'b1010, "R8 refresh both lows on");
    tick(8);  expect_out(4'b1010, "R8 refresh window last cycle");
    tick(1);  expect_out(4'b1000, "R6 b_lo off at refresh end");
    tick(12); expect_out(4'b1000, "R8 upper still held");
    tick(1);  expect_out(4'b1001, "R7 b_hi on after upper enable");
    tick(3);  expect_out(4'b1001, "R4 dir0 steady");

    // direction flip in run
    dir_in = 1'b1;
    tick(2); expect_out(4'b1001, "R12 dir not yet through sync");
    tick(1); expect_out(4'b0000, "R6 R7 immediate turn-off");
    tick(2); expect_out(4'b0000, "R6 low delay pending");
    tick(1); expect_out(4'b0010, "R6 b_lo on after lo_dead");
    tick(1); expect_out(4'b0010, "R7 a_hi delay independent");
    tick(1); expect_out(4'b0110, "R4 dir1 a_hi on after hi_dead");

    // chop mode
    hen_in = 1'b0;
    tick(2); expect_out(4'b0110, "R12 hen not yet through sync");
    tick(1); expect_out(4'b0010, "R5 chop high sides off");
    tick(2); expect_out(4'b0010, "R5 low follows dir");

    // short hen pulse, cancelled turn-on
    hen_in = 1'b1;
    tick(2); expect_out(4'b0010, "R9 pending turn-on");
    hen_in = 1'b0;
    tick(1); expect_out(4'b0010, "R9 no glitch a");
    tick(1); expect_out(4'b0010, "R9 no glitch b");
    tick(3); expect_out(4'b0010, "R9 cancelled");
    hen_in = 1'b1;
    tick(7); expect_out(4'b0010, "R9 count restarted");
    tick(1); expect_out(4'b0110, "R9 full delay after restart");

    // undervoltage
    uv_in = 1'b1;
    tick(1); expect_out(4'b0000, "R3 uv forces off");
    dir_in = 1'b0;
    tick(4); expect_out(4'b0000, "R3 uv ignores dir");
    uv_in = 1'b0; lo_dead = '0; hi_dead = '0;
    tick(1);  expect_out(4'b0000, "R8 release edge");
    tick(1);  expect_out(4'b1010, "R10 zero lo delay refresh");
    tick(11); expect_out(4'b1010, "R8 uv refresh window");
    tick(1);  expect_out(4'b1000, "R8 refresh end after uv");
    tick(7);  expect_out(4'b1000, "R8 upper held after uv");
    tick(1);  expect_out(4'b1001, "R10 zero hi delay upper enable");

    dir_in = 1'b1;
    tick(2); expect_out(4'b1001, "R12 dir sync zero delay");
    tick(1); expect_out(4'b0110, "R11 swap in one edge R10");

    // disable in run
    dis_in = 1'b1;
    tick(2); expect_out(4'b0110, "R12 dis not yet through sync");
    tick(1); expect_out(4'b0000, "R2 disable forces off");
    dir_in = 1'b0; hen_in = 1'b0;
    tick(5); expect_out(4'b0000, "R2 disable overrides inputs");

    @(negedge clk);
    #1;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule